// File: doc/BRIEF.md
# Write Protection and Power-Mode Controller

This block decides which effects a decoded write or mode command is allowed to have. A serial front end, which is not part of this block, hands it one-cycle strobes. It holds two pieces of state. The first is a programming-enable latch, which is cleared at power-on, set by an enable command and cleared by a disable command. The second is a power-down latch, which is set by a sleep command and cleared by a wake command.

On every write strobe the block issues one-cycle permits. There is a permit for the general memory, and there is a pair of per-channel permits for the converter registers. For a converter write the pair gives one of three outcomes: the output and the stored code both change, only the live output changes, or nothing changes. Which outcome applies depends on the protect pin and the enable latch.

The power side combines the sleep latch with a forcing pin. It drives the converter standby flag and the per-channel output enables. It also drives a deeper memory standby flag, which is raised only while the device is asleep and chip select is high. The three external pins pass through a configurable synchronizer before use.

Top module: `pmc_wp_power_ctrl`

## Requirements
- R1: While `rst_n` is low, all permits are 0, `dac_standby_o` is 1, `mem_standby_o` is 0 and `dac_out_en_o` is all 0. Reset clears both the enable latch and the sleep latch.
- R2: `wren_i` sets the enable latch at the clock edge and `wrds_i` clears it. When both are high in the same cycle, the latch ends cleared. The latch keeps its value with no command present.
- R3: A strobe of `write_i` with `write_dac_i`=0 pulses `mem_wr_ok_o` high for exactly the next cycle only if the enable latch was set before that edge, whatever the level of `protect_i`. A command in the same cycle as the write only affects later writes. All converter permits stay 0.
- R4: A converter write (`write_i`=1, `write_dac_i`=1) with the synchronized `protect_i`=1 and the latch set raises bit `write_ch_i` of both `dac_out_upd_o` and `dac_reg_wr_ok_o` for the next cycle.
- R5: A converter write with `protect_i`=1 and the latch clear raises bit `write_ch_i` of `dac_out_upd_o` only. `dac_reg_wr_ok_o` stays 0.
- R6: A converter write with `protect_i`=0 leaves both converter permit vectors at 0, whether the latch is set or clear.
- R7: The converter permits are one-hot at bit `write_ch_i`. A channel index of `NUM_CH` or above gives all-zero permits.
- R8: While the synchronized `pd_i` is 0 the device is asleep, and `pden_i` and `pdds_i` leave the sleep latch unchanged. A latch value set earlier reappears once `pd_i` returns high.
- R9: While the synchronized `pd_i` is 1, `pden_i` sets the sleep latch and `pdds_i` clears it. When both are high, sleep wins. The latch persists between commands, and `dac_standby_o` follows one cycle after the command.
- R10: `dac_standby_o` equals the sleep condition, which is pd low or the latch set. `dac_out_en_o` is all 1 when it is 0 and all 0 when it is 1.
- R11: `mem_standby_o` is 1 exactly when the sleep condition holds and the synchronized `cs_i` is 1. It is re-evaluated every cycle.
- R12: A change on `pd_i`, `cs_i` or `protect_i` takes effect after `SYNC_STAGES` synchronizer flops. A `pd_i` change reaches `dac_standby_o` exactly `SYNC_STAGES`+1 clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wren_i | input | 1 | Programming-enable command strobe |
| wrds_i | input | 1 | Programming-disable command strobe |
| pden_i | input | 1 | Sleep command strobe |
| pdds_i | input | 1 | Wake command strobe |
| write_i | input | 1 | Write command strobe |
| write_dac_i | input | 1 | Write target: 1 for converter register, 0 for general memory |
| write_ch_i | input | CH_W | Converter channel index of the write |
| protect_i | input | 1 | Protect pin; low forbids converter changes |
| pd_i | input | 1 | Power-down pin; low forces sleep |
| cs_i | input | 1 | Chip select pin; high while deselected |
| mem_wr_ok_o | output | 1 | One-cycle general memory commit permit |
| dac_reg_wr_ok_o | output | NUM_CH | One-cycle stored converter code permit, per channel |
| dac_out_upd_o | output | NUM_CH | One-cycle live converter output update permit, per channel |
| dac_standby_o | output | 1 | Converter section in standby |
| dac_out_en_o | output | NUM_CH | Converter output drive enable; 0 means high impedance |
| mem_standby_o | output | 1 | Deep standby of the memory section |

## Verification
The hardest situation to reach is a sleep latch that was set while the pd pin was high, followed by a wake command issued while the pin is low. That latch must survive the ignored command and show itself once the pin rises again. The directed sequence builds exactly this order, letting the synchronizer settle after each pin change. The second hard situation is a write that lands in the same cycle as an enable or disable command. The random phase reaches it by mixing all strobes in every cycle over many pin settings, including an out-of-range channel index.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   // Write target carried with the write strobe
   typedef enum logic {
      TGT_MEM = 1'b0,
      TGT_DAC = 1'b1
   } pmc_tgt_e;

   // Per-cycle command bundle after decode
   typedef struct packed {
      logic wren;
      logic wrds;
      logic pden;
      logic pdds;
   } pmc_cmd_t;

   localparam int unsigned PMC_MAX_SYNC = 4;
   localparam int unsigned PMC_MAX_CH   = 64;

   // Next value of a set/clear latch where the clear side has priority
   function automatic logic latch_clr_wins(input logic q, input logic set, input logic clr);
      logic n;
      n = q;
      if (set) n = 1'b1;
      if (clr) n = 1'b0;
      return n;
   endfunction

   // Next value of a set/clear latch where the set side has priority
   function automatic logic latch_set_wins(input logic q, input logic set, input logic clr);
      logic n;
      n = q;
      if (clr) n = 1'b0;
      if (set) n = 1'b1;
      return n;
   endfunction

endpackage

// File: rtl/pmc_pin_sync.sv
module pmc_pin_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES > pmc_pkg::PMC_MAX_SYNC) begin : g_bad_stages
      $error("pmc_pin_sync: STAGES exceeds limit");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [STAGES-1:0] chain_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
         end else begin
            chain_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
               chain_q[i] <= chain_q[i-1];
            end
         end
      end

      assign q_o = chain_q[STAGES-1];
   end

endmodule

// File: rtl/pmc_prog_latch.sv
module pmc_prog_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic en_o
);

   logic en_q;
   logic en_d;

   // Disable is the safe side: it wins a tie
   always_comb begin
      en_d = pmc_pkg::latch_clr_wins(en_q, set_i, clr_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else begin
         en_q <= en_d;
      end
   end

   // Value before the current edge; writes in the same cycle see this
   assign en_o = en_q;

endmodule

// File: rtl/pmc_power_ctl.sv
module pmc_power_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic pden_i,
   input  logic pdds_i,
   input  logic pd_high_i,
   input  logic cs_high_i,
   output logic dac_standby_o,
   output logic mem_standby_o
);

   logic sleep_q;
   logic sleep_d;
   logic asleep_d;
   logic dac_sb_q;
   logic mem_sb_q;

   // Commands only act while the forcing pin is released
   always_comb begin
      if (pd_high_i) begin
         sleep_d = pmc_pkg::latch_set_wins(sleep_q, pden_i, pdds_i);
      end else begin
         sleep_d = sleep_q;
      end
      asleep_d = !pd_high_i || sleep_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sleep_q  <= 1'b0;
         dac_sb_q <= 1'b1;
         mem_sb_q <= 1'b0;
      end else begin
         sleep_q  <= sleep_d;
         dac_sb_q <= asleep_d;
         mem_sb_q <= asleep_d && cs_high_i;
      end
   end

   assign dac_standby_o = dac_sb_q;
   assign mem_standby_o = mem_sb_q;

endmodule

// File: rtl/pmc_write_gate.sv
module pmc_write_gate #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CH_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              write_i,
   input  pmc_pkg::pmc_tgt_e tgt_i,
   input  logic [CH_W-1:0]   ch_i,
   input  logic              prot_high_i,
   input  logic              prog_en_i,
   output logic              mem_ok_o,
   output logic [NUM_CH-1:0] reg_ok_o,
   output logic [NUM_CH-1:0] out_ok_o
);

   logic [NUM_CH-1:0] ch_sel;
   logic              dac_wr;
   logic              mem_wr;
   logic              mem_ok_q;
   logic [NUM_CH-1:0] reg_ok_q;
   logic [NUM_CH-1:0] out_ok_q;

   // Per-channel decode; indices past NUM_CH match no channel
   for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
      assign ch_sel[g] = (ch_i == CH_W'(g));
   end

   assign dac_wr = write_i && (tgt_i == pmc_pkg::TGT_DAC);
   assign mem_wr = write_i && (tgt_i == pmc_pkg::TGT_MEM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_ok_q <= 1'b0;
         reg_ok_q <= '0;
         out_ok_q <= '0;
      end else begin
         mem_ok_q <= mem_wr && prog_en_i;
         if (dac_wr && prot_high_i) begin
            out_ok_q <= ch_sel;
            reg_ok_q <= prog_en_i ? ch_sel : '0;
         end else begin
            out_ok_q <= '0;
            reg_ok_q <= '0;
         end
      end
   end

   assign mem_ok_o = mem_ok_q;
   assign reg_ok_o = reg_ok_q;
   assign out_ok_o = out_ok_q;

endmodule

// File: rtl/pmc_wp_power_ctrl.sv
module pmc_wp_power_ctrl #(
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wren_i,
   input  logic              wrds_i,
   input  logic              pden_i,
   input  logic              pdds_i,
   input  logic              write_i,
   input  logic              write_dac_i,
   input  logic [CH_W-1:0]   write_ch_i,
   input  logic              protect_i,
   input  logic              pd_i,
   input  logic              cs_i,
   output logic              mem_wr_ok_o,
   output logic [NUM_CH-1:0] dac_reg_wr_ok_o,
   output logic [NUM_CH-1:0] dac_out_upd_o,
   output logic              dac_standby_o,
   output logic [NUM_CH-1:0] dac_out_en_o,
   output logic              mem_standby_o
);

   if (NUM_CH < 1 || NUM_CH > pmc_pkg::PMC_MAX_CH) begin : g_bad_ch
      $error("pmc_wp_power_ctrl: NUM_CH out of range");
   end
   if (SYNC_STAGES > pmc_pkg::PMC_MAX_SYNC) begin : g_bad_sync
      $error("pmc_wp_power_ctrl: SYNC_STAGES out of range");
   end

   pmc_pkg::pmc_cmd_t cmd;
   logic              prot_s;
   logic              pd_s;
   logic              cs_s;
   logic              prog_en;
   pmc_pkg::pmc_tgt_e tgt;

   assign cmd.wren = wren_i;
   assign cmd.wrds = wrds_i;
   assign cmd.pden = pden_i;
   assign cmd.pdds = pdds_i;
   assign tgt      = write_dac_i ? pmc_pkg::TGT_DAC : pmc_pkg::TGT_MEM;

   // Reset values of the pins are the safe levels: protected, asleep, deselected
   pmc_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_prot (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (protect_i),
      .q_o   (prot_s)
   );

   pmc_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_pd (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pd_i),
      .q_o   (pd_s)
   );

   pmc_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (cs_i),
      .q_o   (cs_s)
   );

   pmc_prog_latch u_prog (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (cmd.wren),
      .clr_i (cmd.wrds),
      .en_o  (prog_en)
   );

   pmc_power_ctl u_pwr (
      .clk           (clk),
      .rst_n         (rst_n),
      .pden_i        (cmd.pden),
      .pdds_i        (cmd.pdds),
      .pd_high_i     (pd_s),
      .cs_high_i     (cs_s),
      .dac_standby_o (dac_standby_o),
      .mem_standby_o (mem_standby_o)
   );

   pmc_write_gate #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .write_i     (write_i),
      .tgt_i       (tgt),
      .ch_i        (write_ch_i),
      .prot_high_i (prot_s),
      .prog_en_i   (prog_en),
      .mem_ok_o    (mem_wr_ok_o),
      .reg_ok_o    (dac_reg_wr_ok_o),
      .out_ok_o    (dac_out_upd_o)
   );

   // Output drivers go high impedance while the converter section sleeps
   for (genvar g = 0; g < NUM_CH; g++) begin : g_oe
      assign dac_out_en_o[g] = !dac_standby_o;
   end

endmodule

// File: rtl/pmc_wp_power_ctrl_chk.sv
module pmc_wp_power_ctrl_chk #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CH_W   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              write_i,
   input logic              write_dac_i,
   input logic              wrds_i,
   input logic              mem_wr_ok_o,
   input logic [NUM_CH-1:0] dac_reg_wr_ok_o,
   input logic [NUM_CH-1:0] dac_out_upd_o,
   input logic              dac_standby_o,
   input logic              mem_standby_o
);

   // R4, R5: a stored-code permit never comes without the output permit
   p_reg_needs_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_reg_wr_ok_o & ~dac_out_upd_o) == '0);

   // R7: at most one channel per write
   p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dac_out_upd_o));

   // R6: converter permits only follow a converter write strobe
   p_out_after_dac_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|dac_out_upd_o) |-> $past(write_i && write_dac_i));

   // R3: memory permit only follows a memory write strobe
   p_mem_after_mem_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_ok_o |-> $past(write_i && !write_dac_i));

   // R2: a write right after a disable command commits nothing stored
   p_wrds_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wrds_i) && write_i) |=> (!mem_wr_ok_o && dac_reg_wr_ok_o == '0));

   // R11: deep standby implies converter standby
   p_deep_implies_dac_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_standby_o |-> dac_standby_o);

endmodule

bind pmc_wp_power_ctrl pmc_wp_power_ctrl_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .write_i         (write_i),
   .write_dac_i     (write_dac_i),
   .wrds_i          (wrds_i),
   .mem_wr_ok_o     (mem_wr_ok_o),
   .dac_reg_wr_ok_o (dac_reg_wr_ok_o),
   .dac_out_upd_o   (dac_out_upd_o),
   .dac_standby_o   (dac_standby_o),
   .mem_standby_o   (mem_standby_o)
);

// File: tb/pmc_wp_power_ctrl_tb.sv
module pmc_wp_power_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NCH  = 3;
   localparam int SYNC = 2;
   localparam int CW   = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wren = 0, wrds = 0, pden = 0, pdds = 0, wr = 0, wdac = 0;
   logic [CW-1:0] wch = '0;
   logic prot = 0, pd = 0, cs = 1;
   logic mem_ok, dac_sb, mem_sb;
   logic [NCH-1:0] reg_ok, out_upd, oe;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   // Bench model state
   bit m_en = 0;
   bit m_sl = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pmc_wp_power_ctrl #(.NUM_CH(NCH), .SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .wren_i(wren), .wrds_i(wrds), .pden_i(pden), .pdds_i(pdds),
      .write_i(wr), .write_dac_i(wdac), .write_ch_i(wch),
      .protect_i(prot), .pd_i(pd), .cs_i(cs),
      .mem_wr_ok_o(mem_ok), .dac_reg_wr_ok_o(reg_ok), .dac_out_upd_o(out_upd),
      .dac_standby_o(dac_sb), .dac_out_en_o(oe), .mem_standby_o(mem_sb)
   );

   function automatic logic [3*NCH+2:0] pack(input logic a, input logic [NCH-1:0] b,
      input logic [NCH-1:0] c, input logic d, input logic [NCH-1:0] e, input logic f);
      return {a, b, c, d, e, f};
   endfunction

   task automatic check(input string req, input logic [3*NCH+2:0] act, input logic [3*NCH+2:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%b exp=%b", req, act, exp);
      end
   endtask

   // Outputs expected one edge after a cycle with the given strobes, pins settled
   task automatic cyc(input string req, input bit a_wren, input bit a_wrds, input bit a_pden,
      input bit a_pdds, input bit a_wr, input bit a_dac, input int a_ch);
      logic e_mem, e_sb, e_msb;
      logic [NCH-1:0] e_out, e_reg, e_oe;
      wren = a_wren; wrds = a_wrds; pden = a_pden; pdds = a_pdds;
      wr = a_wr; wdac = a_dac; wch = CW'(a_ch);
      e_mem = a_wr && !a_dac && m_en;
      e_out = '0;
      if (a_wr && a_dac && prot && a_ch < NCH) e_out[a_ch] = 1'b1;
      e_reg = m_en ? e_out : '0;
      if (a_wrds) m_en = 0; else if (a_wren) m_en = 1;
      if (pd) begin
         if (a_pden) m_sl = 1; else if (a_pdds) m_sl = 0;
      end
      e_sb  = !pd || m_sl;
      e_msb = e_sb && cs;
      e_oe  = e_sb ? '0 : '1;
      @(negedge clk);
      check(req, pack(mem_ok, reg_ok, out_upd, dac_sb, oe, mem_sb),
                 pack(e_mem, e_reg, e_out, e_sb, e_oe, e_msb));
      wren = 0; wrds = 0; pden = 0; pdds = 0; wr = 0; wdac = 0;
   endtask

   task automatic set_pins(input bit a_prot, input bit a_pd, input bit a_cs);
      prot = a_prot; pd = a_pd; cs = a_cs;
      repeat (SYNC + 2) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", pack(mem_ok, reg_ok, out_upd, dac_sb, oe, mem_sb),
                  pack(1'b0, '0, '0, 1'b1, '0, 1'b0));
      rst_n = 1;
      @(negedge clk);
      set_pins(1, 1, 0);
      cyc("R10 awake idle", 0,0,0,0,0,0,0);

      // R3 memory write blocked with latch clear, then allowed after enable
      cyc("R3 blocked", 0,0,0,0,1,0,0);
      cyc("R3 same-cycle wren", 1,0,0,0,1,0,0);
      cyc("R3 enabled", 0,0,0,0,1,0,0);
      set_pins(0, 1, 0);
      cyc("R3 protect low", 0,0,0,0,1,0,0);
      // R6 protect low blocks both
      cyc("R6 prot low en set", 0,0,0,0,1,1,1);
      set_pins(1, 1, 0);
      // R4 both permits
      cyc("R4 ch2", 0,0,0,0,1,1,2);
      cyc("R4 ch0", 0,0,0,0,1,1,0);
      // R7 out-of-range channel
      cyc("R7 ch3", 0,0,0,0,1,1,3);
      // R2 tie: disable wins, then write blocked
      cyc("R2 tie", 1,1,0,0,0,0,0);
      cyc("R2 after tie mem", 0,0,0,0,1,0,0);
      // R5 output only
      cyc("R5 ch1", 0,0,0,0,1,1,1);
      cyc("R2 hold clear", 0,0,0,0,0,0,0);
      cyc("R5 persists", 0,0,0,0,1,1,2);

      // R9 sleep and wake, tie sleep wins
      cyc("R9 pden", 0,0,1,0,0,0,0);
      cyc("R9 hold", 0,0,0,0,0,0,0);
      cyc("R9 pdds", 0,0,0,1,0,0,0);
      cyc("R9 tie", 0,0,1,1,0,0,0);
      // R11 deep standby with cs high
      set_pins(1, 1, 1);
      cyc("R11 deep", 0,0,0,0,0,0,0);
      // R8 wake ignored while pd low, latch reappears
      set_pins(1, 0, 1);
      cyc("R8 pdds ignored", 0,0,0,1,0,0,0);
      set_pins(1, 1, 1);
      cyc("R8 latch kept", 0,0,0,0,0,0,0);
      cyc("R9 wake", 0,0,0,1,0,0,0);
      cyc("R11 awake cs high", 0,0,0,0,0,0,0);
      // R8 sleep ignored while pd low
      set_pins(1, 0, 0);
      cyc("R8 pden ignored", 0,0,1,0,0,0,0);
      set_pins(1, 1, 0);
      cyc("R8 stays awake", 0,0,0,0,0,0,0);

      // R12 pd latency: SYNC+1 edges to dac_standby
      pd = 0;
      repeat (SYNC) @(negedge clk);
      check("R12 before", pack(0,'0,'0,dac_sb,'0,0), pack(0,'0,'0,1'b0,'0,0));
      @(negedge clk);
      check("R12 at", pack(0,'0,'0,dac_sb,'0,0), pack(0,'0,'0,1'b1,'0,0));
      set_pins(1, 1, 0);

      // Random phase
      for (int s = 0; s < 60; s++) begin
         set_pins($urandom_range(1), $urandom_range(1), $urandom_range(1));
         for (int k = 0; k < 25; k++) begin
            cyc("R2-R11 random", $urandom_range(3) == 0, $urandom_range(4) == 0,
                $urandom_range(5) == 0, $urandom_range(5) == 0,
                $urandom_range(1), $urandom_range(1), $urandom_range(3));
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule